// File: doc/BRIEF.md
# Channel Self-Refresh Controller

This block moves one memory channel into DRAM self-refresh and back out again. It keeps an idle counter. Any access clears the counter, and the counter is held at zero while the controller still has work in flight. Once the controller is drained and no access arrives, the counter climbs toward a programmable threshold. When it reaches the threshold and autonomous entry is enabled, the channel enters self-refresh. An external power-control unit can also request entry for the channel directly.

Two events wake the channel: an external wake message, or a new transaction arriving while the channel sleeps. The block then issues an exit command and holds new traffic off for a programmable delay before the channel is active again. Core power may be gated only while the channel sits in self-refresh.

Top module: `chan_srefresh_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sr_enter_o`, `sr_exit_o`, `in_sr_o`, `core_gate_ok_o` and `txn_hold_o` are all 0.
- R2: With `auto_en_i`=1, `drained_i`=1, no access and threshold L, `sr_enter_o` rises L+1 clock edges after `drained_i` is first sampled high.
- R3: An access clears the idle counter. An access in the cycle the counter stands at the threshold cancels entry, and counting restarts from zero.
- R4: While `drained_i`=0 the idle counter stays at zero and no autonomous entry occurs.
- R5: With `auto_en_i`=0 the idle counter never causes entry.
- R6: `sleep_req_i` in the active state causes entry one edge later, whatever the value of `auto_en_i`. An access in the same cycle suppresses that entry.
- R7: `sr_enter_o` is a one-cycle pulse. `in_sr_o` rises on the next cycle and stays high until a wake message or a new transaction arrives.
- R8: In self-refresh, `wake_i` or `new_txn_i` makes `sr_exit_o` pulse for exactly one cycle on the next cycle, and `in_sr_o` falls in that same cycle.
- R9: `txn_hold_o` is 1 from the entry pulse until the exit delay D (`exit_dly_i`) has elapsed. The exit phase lasts D+1 cycles, starting with the exit pulse.
- R10: `core_gate_ok_o` is 1 only while `in_sr_o` is 1.
- R11: In the active state, `wake_i` and `new_txn_i` have no effect: there is no exit pulse and no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| access_i | input | 1 | Access to the controller this cycle |
| drained_i | input | 1 | Controller has no outstanding work |
| auto_en_i | input | 1 | Enables autonomous idle entry |
| idle_limit_i | input | CNT_W | Idle-count threshold |
| sleep_req_i | input | 1 | External power-control entry request |
| wake_i | input | 1 | External wake message |
| new_txn_i | input | 1 | New incoming transaction |
| exit_dly_i | input | DLY_W | Cycles of hold-off after the exit command |
| sr_enter_o | output | 1 | Self-refresh entry command strobe |
| sr_exit_o | output | 1 | Self-refresh exit command strobe |
| in_sr_o | output | 1 | Channel is in self-refresh |
| core_gate_ok_o | output | 1 | Core power may be removed |
| txn_hold_o | output | 1 | New transactions must be held off |

## Verification
Autonomous entry is due L+1 edges after `drained_i` is first sampled high. Entry on request is due one edge after the request. The exit pulse is due one edge after the wake or the transaction, and `txn_hold_o` falls D+1 edges after that pulse appears. The bench drives inputs just after a falling edge and samples at the next falling edge. Each sample therefore reflects exactly one rising edge, and the bench counts sample points from the stimulus up to the expected edge. It compares those counts with the formulas across a table of threshold and delay pairs, including zero.

// File: rtl/chan_srefresh_ctl.sv
`timescale 1ns/1ps
module chan_srefresh_ctl #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_i,
  input  logic             drained_i,
  input  logic             auto_en_i,
  input  logic [CNT_W-1:0] idle_limit_i,
  input  logic             sleep_req_i,
  input  logic             wake_i,
  input  logic             new_txn_i,
  input  logic [DLY_W-1:0] exit_dly_i,
  output logic             sr_enter_o,
  output logic             sr_exit_o,
  output logic             in_sr_o,
  output logic             core_gate_ok_o,
  output logic             txn_hold_o
);
  typedef enum logic [1:0] {ST_ACT, ST_ENT, ST_SR, ST_EXT} st_t;

  st_t             st;
  logic [CNT_W-1:0] idle_cnt;
  logic [DLY_W-1:0] dly_cnt;
  logic            at_limit, go_sleep, go_wake, exit_done;

  assign at_limit  = idle_cnt >= idle_limit_i;
  assign go_sleep  = (st == ST_ACT) && !access_i &&
                     (sleep_req_i || (auto_en_i && drained_i && at_limit));
  assign go_wake   = (st == ST_SR) && (wake_i || new_txn_i);
  assign exit_done = (st == ST_EXT) && (dly_cnt == exit_dly_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_ACT;
    end else begin
      unique case (st)
        ST_ACT:  if (go_sleep)  st <= ST_ENT;
        ST_ENT:                 st <= ST_SR;
        ST_SR:   if (go_wake)   st <= ST_EXT;
        ST_EXT:  if (exit_done) st <= ST_ACT;
        default:                st <= ST_ACT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != ST_ACT || access_i || !drained_i)
      idle_cnt <= '0;
    else if (!at_limit)
      idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != ST_EXT)
      dly_cnt <= '0;
    else if (!exit_done)
      dly_cnt <= dly_cnt + 1'b1;
  end

  assign sr_enter_o     = (st == ST_ENT);
  assign sr_exit_o      = (st == ST_EXT) && (dly_cnt == '0);
  assign in_sr_o        = (st == ST_SR);
  assign core_gate_ok_o = (st == ST_SR);
  assign txn_hold_o     = (st != ST_ACT);
endmodule

// File: rtl/chan_srefresh_ctl_chk.sv
`timescale 1ns/1ps
module chan_srefresh_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic access_i,
  input logic auto_en_i,
  input logic sleep_req_i,
  input logic wake_i,
  input logic new_txn_i,
  input logic sr_enter_o,
  input logic sr_exit_o,
  input logic in_sr_o,
  input logic core_gate_ok_o,
  input logic txn_hold_o
);
  // R7
  enter_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_o |=> !sr_enter_o && in_sr_o);
  // R7
  sr_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr_o && !wake_i && !new_txn_i |=> in_sr_o);
  // R8
  exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr_o && (wake_i || new_txn_i) |=> sr_exit_o && !in_sr_o);
  // R8
  exit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_o |=> !sr_exit_o);
  // R10
  gate_only_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_gate_ok_o |-> in_sr_o);
  // R3
  access_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_hold_o && access_i |=> !sr_enter_o);
  // R5
  no_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_hold_o && !auto_en_i && !sleep_req_i |=> !sr_enter_o);
  // R11
  active_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_hold_o && (wake_i || new_txn_i) |=> !sr_exit_o);
  // R9
  strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_enter_o, sr_exit_o, in_sr_o}) && ((sr_enter_o || sr_exit_o || in_sr_o) -> txn_hold_o));
endmodule

bind chan_srefresh_ctl chan_srefresh_ctl_chk i_chk (.*);

// File: tb/test_chan_srefresh_ctl.sv
`timescale 1ns/1ps
module test_chan_srefresh_ctl;
  logic clk = 0, rst_n = 0;
  logic access_i = 0, drained_i = 0, auto_en_i = 0, sleep_req_i = 0, wake_i = 0, new_txn_i = 0;
  logic [15:0] idle_limit_i = 0;
  logic [7:0]  exit_dly_i = 0;
  logic sr_enter_o, sr_exit_o, in_sr_o, core_gate_ok_o, txn_hold_o;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam int unsigned VEC [5][2] = '{'{0, 0}, '{1, 2}, '{5, 0}, '{12, 7}, '{3, 1}};

  always #2.5 clk = ~clk;

  chan_srefresh_ctl i_chan_srefresh_ctl (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic int count_to_enter();
    return 0;
  endfunction

  task automatic wait_enter(output int n);
    n = 0;
    for (int i = 1; i <= 200; i++) begin
      cyc();
      if (sr_enter_o) begin n = i; break; end
    end
  endtask

  task automatic leave_sr(bit via_txn, int d, string req);
    int m;
    if (via_txn) new_txn_i = 1; else wake_i = 1;
    cyc();
    wake_i = 0; new_txn_i = 0;
    check({req, " exit pulse"}, sr_exit_o, 1);
    check({req, " in_sr low at exit"}, in_sr_o, 0);
    check("R10 gate low at exit", core_gate_ok_o, 0);
    m = 0;
    for (int i = 1; i <= 300; i++) begin
      cyc();
      if (i == 1 && d >= 1) check("R8 exit pulse width", sr_exit_o, 0);
      if (!txn_hold_o) begin m = i; break; end
    end
    check("R9 exit hold length", m, d + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, any;
    cyc(3);
    check("R1 enter in reset", sr_enter_o, 0);
    check("R1 in_sr in reset", in_sr_o, 0);
    check("R1 gate in reset", core_gate_ok_o, 0);
    check("R1 hold in reset", txn_hold_o, 0);
    rst_n = 1;
    cyc();
    check("R1 exit after reset", sr_exit_o, 0);

    foreach (VEC[k]) begin
      auto_en_i = 1; idle_limit_i = 16'(VEC[k][0]); exit_dly_i = 8'(VEC[k][1]);
      drained_i = 1;
      wait_enter(n);
      check("R2 entry latency", n, int'(VEC[k][0]) + 1);
      check("R9 hold at entry", txn_hold_o, 1);
      drained_i = 0;
      cyc();
      check("R7 enter single", sr_enter_o, 0);
      check("R7 in_sr follows", in_sr_o, 1);
      check("R10 gate in sr", core_gate_ok_o, 1);
      cyc(3);
      check("R7 in_sr stays", in_sr_o, 1);
      leave_sr(k % 2, int'(VEC[k][1]), "R8");
    end

    auto_en_i = 0; idle_limit_i = 2; exit_dly_i = 0; drained_i = 1; any = 0;
    for (int i = 0; i < 20; i++) begin cyc(); any |= sr_enter_o | txn_hold_o; end
    check("R5 no entry when disabled", any, 0);

    auto_en_i = 1; drained_i = 0; any = 0;
    for (int i = 0; i < 10; i++) begin cyc(); any |= sr_enter_o | txn_hold_o; end
    check("R4 no entry while busy", any, 0);
    drained_i = 1;
    wait_enter(n);
    check("R4 counter restarts at zero", n, 3);
    drained_i = 0;
    cyc();
    leave_sr(1, 0, "R8 txn");

    idle_limit_i = 3; drained_i = 1;
    cyc(3);
    check("R3 no entry before threshold", txn_hold_o, 0);
    access_i = 1;
    cyc();
    check("R3 access cancels entry", sr_enter_o, 0);
    access_i = 0;
    wait_enter(n);
    check("R3 count restarts after access", n, 4);
    drained_i = 0;
    cyc();
    leave_sr(0, 0, "R8");

    auto_en_i = 0; sleep_req_i = 1; access_i = 1;
    cyc();
    check("R6 access suppresses request", sr_enter_o, 0);
    access_i = 0;
    cyc();
    sleep_req_i = 0;
    check("R6 request entry", sr_enter_o, 1);
    cyc();
    check("R6 in_sr after request", in_sr_o, 1);
    leave_sr(0, 0, "R8");

    wake_i = 1; new_txn_i = 1; any = 0;
    for (int i = 0; i < 3; i++) begin cyc(); any |= sr_exit_o | txn_hold_o | in_sr_o; end
    wake_i = 0; new_txn_i = 0;
    check("R11 wake ignored when active", any, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule